// File: doc/BRIEF.md
# Flash Program and Erase Sequencer with Toggle-Bit Polling

This block sits on the host side of an asynchronous parallel NOR flash bus. It takes a single request to program one byte, to erase the whole chip, or to erase a chosen set of sectors. It then sends the matching unlock and command write cycles. The strobe timing is built from clock counts: a low phase on the write strobe, a recovery phase with all strobes high, and an output-enable-to-sample delay on reads.

After the command script, the block checks for completion by reading one poll address twice and comparing DQ6 between the two reads. If DQ6 still differs and DQ5 shows the timing-limit flag, it does one more pair of reads, because DQ6 can stop toggling in the same cycle that DQ5 rises. A persistent toggle, or too many polling pairs, is reported as an error. In both of those cases the block first writes a reset command so the flash goes back to read mode.

The host sees a level `busy_o` and a one-cycle `done_o` pulse, with `err_o` valid during that pulse.

Top module: `flash_prog_poll`

## Requirements
- R1: While reset is asserted and after it is released, `ce_no`, `we_no` and `oe_no` are high, `fd_oe_o`, `busy_o`, `done_o` and `err_o` are low.
- R2: Opcode 0 (byte program) issues exactly four writes as (address/data): 5555h/AAh, 2AAAh/55h, 5555h/A0h, then `addr_i`/`data_i`. It then polls at `addr_i`.
- R3: During each write cycle, `we_no` stays low for exactly WE_LO clocks. Throughout that window `ce_no` is low, `oe_no` is high, `fd_oe_o` is high, and `fa_o`/`fd_o` are stable. `fd_oe_o` is high at no other time.
- R4: Opcode 1 (chip erase) issues 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h. It then polls at `addr_i`.
- R5: Opcode 2 (sector erase) issues 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h. It then issues one write of data 30h for each set bit of `sec_mask_i`, in ascending bit order. The sector address has the bit index in the top log2(NSEC) address bits and zeros below. Polling uses the address of the lowest selected sector.
- R6: Each poll read holds `ce_no` and `oe_no` low for exactly RD_DLY clocks with `we_no` high, at the poll address.
- R7: If two consecutive poll reads return equal DQ6 (bit 6), the operation ends with `done_o` and `err_o` low.
- R8: If DQ6 differs and the second read has DQ5 (bit 5) set, one more read pair is made. The operation passes if that pair shows equal DQ6.
- R9: If DQ6 still differs in the re-check pair, the block writes F0h to the poll address and then ends with `err_o` high.
- R10: If POLL_MAX pairs in a row differ in DQ6 with DQ5 clear, the block writes F0h to the poll address and then ends with `err_o` high.
- R11: Opcode 3, or opcode 2 with an all-zero mask, ends with `done_o` and `err_o` high on the clock after acceptance, with no bus cycle.
- R12: `req_i` is ignored while `busy_o` is high.
- R13: `done_o` is a single-cycle pulse. `busy_o` is high from the clock after acceptance through the `done_o` cycle. While `busy_o` is low all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start request, sampled when idle |
| op_i | input | 2 | 0 program, 1 chip erase, 2 sector erase, 3 reserved |
| addr_i | input | AW | Target byte address, or poll address for chip erase |
| data_i | input | 8 | Byte to program |
| sec_mask_i | input | NSEC | One bit per sector to erase |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Failure flag, valid with done_o |
| ce_no | output | 1 | Flash chip enable, active low |
| we_no | output | 1 | Flash write strobe, active low |
| oe_no | output | 1 | Flash output enable, active low |
| fa_o | output | AW | Flash address bus |
| fd_o | output | 8 | Flash write data |
| fd_oe_o | output | 1 | Write data drive enable |
| fd_i | input | 8 | Flash read data |

## Verification
A wrong script step counter or a wrong sector pick shows up on the very next rising edge of `we_no` as a wrong address/data pair, so it is caught within one bus cycle. A fault in the poll decision shows up in three ways at the ports: the number of read strobes, whether an F0h write appears, and the value of `err_o`. The bench predicts all three by replaying the toggle and timing-limit pattern of its flash model. Strobe-width or drive-window errors break a per-clock check on the first cycle they occur.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_CHIP = 2'd1, OP_SECT = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_WLO, PH_RD, PH_HI} bus_ph_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_SEC, ST_POLL, ST_RST, ST_FIN} seq_st_e;

  localparam logic [15:0] UNL_A1 = 16'h5555;
  localparam logic [15:0] UNL_A2 = 16'h2AAA;
  localparam logic [7:0]  UNL_D1 = 8'hAA;
  localparam logic [7:0]  UNL_D2 = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_RESET = 8'hF0;
endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int AW     = 19,
  parameter int WE_LO  = 3,
  parameter int WE_HI  = 2,
  parameter int RD_DLY = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          done_o,
  output logic [7:0]    rdata_o,
  output logic          ce_no,
  output logic          we_no,
  output logic          oe_no,
  output logic [AW-1:0] fa_o,
  output logic [7:0]    fd_o,
  output logic          fd_oe_o,
  input  logic [7:0]    fd_i
);
  localparam int MAX_A = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int MAXC  = (MAX_A > RD_DLY) ? MAX_A : RD_DLY;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LO_N = CW'(WE_LO - 1);
  localparam logic [CW-1:0] HI_N = CW'(WE_HI - 1);
  localparam logic [CW-1:0] RD_N = CW'(RD_DLY - 1);

  bus_ph_e       ph_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          addr_q <= addr_i;
          data_q <= data_i;
          ph_q   <= rd_i ? PH_RD : PH_WLO;
          cnt_q  <= rd_i ? RD_N : LO_N;
        end
        PH_WLO: if (cnt_q == '0) begin
          ph_q  <= PH_HI;
          cnt_q <= HI_N;
        end else cnt_q <= cnt_q - 1'b1;
        PH_RD: if (cnt_q == '0) begin
          rdata_q <= fd_i;
          ph_q    <= PH_HI;
          cnt_q   <= HI_N;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HI: if (cnt_q == '0) ph_q <= PH_IDLE;
               else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign done_o  = (ph_q == PH_HI) && (cnt_q == '0);
  assign rdata_o = rdata_q;
  assign ce_no   = !((ph_q == PH_WLO) || (ph_q == PH_RD));
  assign we_no   = (ph_q != PH_WLO);
  assign oe_no   = (ph_q != PH_RD);
  assign fd_oe_o = (ph_q == PH_WLO);
  assign fa_o    = addr_q;
  assign fd_o    = data_q;
endmodule

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_seq_pkg::*;
#(
  parameter int AW = 19
) (
  input  op_e           op_i,
  input  logic [2:0]    step_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [7:0]    tgt_data_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  localparam logic [AW-1:0] A1 = AW'(UNL_A1);
  localparam logic [AW-1:0] A2 = AW'(UNL_A2);

  always_comb begin
    addr_o = A1;
    data_o = UNL_D1;
    unique case (step_i)
      3'd0: begin addr_o = A1; data_o = UNL_D1; end
      3'd1: begin addr_o = A2; data_o = UNL_D2; end
      3'd2: begin addr_o = A1; data_o = (op_i == OP_PROG) ? CMD_PROG : CMD_ERASE; end
      3'd3: begin
        addr_o = (op_i == OP_PROG) ? tgt_addr_i : A1;
        data_o = (op_i == OP_PROG) ? tgt_data_i : UNL_D1;
      end
      3'd4: begin addr_o = A2; data_o = UNL_D2; end
      3'd5: begin addr_o = A1; data_o = CMD_CHIP; end
      default: begin addr_o = A1; data_o = CMD_RESET; end
    endcase
  end
endmodule

// File: rtl/flash_sec_pick.sv
module flash_sec_pick #(
  parameter int NSEC = 8,
  localparam int SB  = $clog2(NSEC)
) (
  input  logic [NSEC-1:0] mask_i,
  output logic            any_o,
  output logic [SB-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NSEC - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = SB'(i);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/flash_prog_poll.sv
module flash_prog_poll
  import flash_seq_pkg::*;
#(
  parameter int AW       = 19,
  parameter int NSEC     = 8,
  parameter int WE_LO    = 3,
  parameter int WE_HI    = 2,
  parameter int RD_DLY   = 3,
  parameter int POLL_MAX = 1024
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      data_i,
  input  logic [NSEC-1:0] sec_mask_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            ce_no,
  output logic            we_no,
  output logic            oe_no,
  output logic [AW-1:0]   fa_o,
  output logic [7:0]      fd_o,
  output logic            fd_oe_o,
  input  logic [7:0]      fd_i
);
  localparam int SB = $clog2(NSEC);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [PW-1:0] PCNT_LAST = PW'(POLL_MAX - 1);

  seq_st_e         st_q;
  op_e             op_q;
  logic            wait_q, rd_idx_q, rech_q, err_q;
  logic [2:0]      step_q;
  logic [AW-1:0]   tgt_a_q, poll_a_q;
  logic [7:0]      tgt_d_q, rd1_q;
  logic [NSEC-1:0] rem_q;
  logic [PW-1:0]   pcnt_q;

  logic            bus_start, bus_rd, bus_done;
  logic [AW-1:0]   bus_a, rom_a;
  logic [7:0]      bus_d, rom_d, bus_rdata;
  logic            rem_any, new_any;
  logic [SB-1:0]   rem_idx, new_idx;
  logic [2:0]      last_step;
  op_e             op_in;

  assign op_in = op_e'(op_i);

  flash_cmd_rom #(.AW(AW)) u_rom (
    .op_i(op_q), .step_i(step_q), .tgt_addr_i(tgt_a_q), .tgt_data_i(tgt_d_q),
    .addr_o(rom_a), .data_o(rom_d)
  );

  flash_sec_pick #(.NSEC(NSEC)) u_pick_rem (.mask_i(rem_q), .any_o(rem_any), .idx_o(rem_idx));
  flash_sec_pick #(.NSEC(NSEC)) u_pick_new (.mask_i(sec_mask_i), .any_o(new_any), .idx_o(new_idx));

  flash_bus_cycle #(.AW(AW), .WE_LO(WE_LO), .WE_HI(WE_HI), .RD_DLY(RD_DLY)) u_bus (
    .clk_i, .rst_ni, .start_i(bus_start), .rd_i(bus_rd), .addr_i(bus_a), .data_i(bus_d),
    .done_o(bus_done), .rdata_o(bus_rdata), .ce_no, .we_no, .oe_no, .fa_o, .fd_o,
    .fd_oe_o, .fd_i
  );

  always_comb begin
    unique case (op_q)
      OP_PROG: last_step = 3'd3;
      OP_CHIP: last_step = 3'd5;
      default: last_step = 3'd4;
    endcase
  end

  always_comb begin
    bus_start = 1'b0;
    bus_rd    = 1'b0;
    bus_a     = '0;
    bus_d     = '0;
    unique case (st_q)
      ST_CMD:  begin bus_start = !wait_q; bus_a = rom_a; bus_d = rom_d; end
      ST_SEC:  begin bus_start = !wait_q; bus_a = {rem_idx, {(AW-SB){1'b0}}}; bus_d = CMD_SECT; end
      ST_POLL: begin bus_start = !wait_q; bus_rd = 1'b1; bus_a = poll_a_q; end
      ST_RST:  begin bus_start = !wait_q; bus_a = poll_a_q; bus_d = CMD_RESET; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_PROG;
      wait_q   <= 1'b0;
      rd_idx_q <= 1'b0;
      rech_q   <= 1'b0;
      err_q    <= 1'b0;
      step_q   <= '0;
      tgt_a_q  <= '0;
      poll_a_q <= '0;
      tgt_d_q  <= '0;
      rd1_q    <= '0;
      rem_q    <= '0;
      pcnt_q   <= '0;
    end else if (st_q == ST_IDLE) begin
      if (req_i) begin
        op_q     <= op_in;
        tgt_a_q  <= addr_i;
        tgt_d_q  <= data_i;
        rem_q    <= sec_mask_i;
        step_q   <= '0;
        wait_q   <= 1'b0;
        rd_idx_q <= 1'b0;
        rech_q   <= 1'b0;
        pcnt_q   <= '0;
        err_q    <= 1'b0;
        poll_a_q <= (op_in == OP_SECT) ? {new_idx, {(AW-SB){1'b0}}} : addr_i;
        if (op_in == OP_RSVD || (op_in == OP_SECT && !new_any)) begin
          err_q <= 1'b1;
          st_q  <= ST_FIN;
        end else st_q <= ST_CMD;
      end
    end else if (st_q == ST_FIN) begin
      st_q <= ST_IDLE;
    end else if (bus_start) begin
      wait_q <= 1'b1;
    end else if (wait_q && bus_done) begin
      wait_q <= 1'b0;
      unique case (st_q)
        ST_CMD: begin
          step_q <= step_q + 1'b1;
          if (step_q == last_step) st_q <= (op_q == OP_SECT) ? ST_SEC : ST_POLL;
        end
        ST_SEC: begin
          rem_q[rem_idx] <= 1'b0;
          if ($countones(rem_q) == 1) st_q <= ST_POLL;
        end
        ST_POLL: begin
          rd_idx_q <= !rd_idx_q;
          if (!rd_idx_q) rd1_q <= bus_rdata;
          else if (rd1_q[6] == bus_rdata[6]) st_q <= ST_FIN;
          else if (rech_q) begin
            err_q <= 1'b1;
            st_q  <= ST_RST;
          end else if (bus_rdata[5]) rech_q <= 1'b1;
          else if (pcnt_q == PCNT_LAST) begin
            err_q <= 1'b1;
            st_q  <= ST_RST;
          end else pcnt_q <= pcnt_q + 1'b1;
        end
        ST_RST: st_q <= ST_FIN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN);
  assign err_o  = done_o && err_q;

  logic unused_any;
  assign unused_any = rem_any;
endmodule

// File: rtl/flash_prog_poll_chk.sv
module flash_prog_poll_chk #(
  parameter int AW = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          ce_no,
  input logic          we_no,
  input logic          oe_no,
  input logic [AW-1:0] fa_o,
  input logic [7:0]    fd_o,
  input logic          fd_oe_o
);
  p_oe_high_in_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (oe_no && !ce_no));
  p_drive_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fd_oe_o |-> !we_no);
  p_write_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && $past(!we_no)) |-> ($stable(fa_o) && $stable(fd_o)));
  p_read_strobes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (we_no && !ce_no));
  p_err_with_done_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_done_single_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  p_idle_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_no && we_no && oe_no && !fd_oe_o));
endmodule

bind flash_prog_poll flash_prog_poll_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .ce_no(ce_no), .we_no(we_no), .oe_no(oe_no), .fa_o(fa_o), .fd_o(fd_o), .fd_oe_o(fd_oe_o)
);

// File: tb/flash_prog_poll_test.sv
module flash_prog_poll_test;
  localparam int AW = 19, NSEC = 8, WE_LO = 3, WE_HI = 2, RD_DLY = 2, PMAX = 4;
  localparam int INF = 1000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic [NSEC-1:0] mask = '0;
  logic busy, done, err, ce_n, we_n, oe_n, fd_oe;
  logic [AW-1:0] fa;
  logic [7:0] fdo, fdi;

  always #2 clk = ~clk;

  flash_prog_poll #(.AW(AW), .NSEC(NSEC), .WE_LO(WE_LO), .WE_HI(WE_HI), .RD_DLY(RD_DLY),
    .POLL_MAX(PMAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr), .data_i(data),
    .sec_mask_i(mask), .busy_o(busy), .done_o(done), .err_o(err), .ce_no(ce_n), .we_no(we_n),
    .oe_no(oe_n), .fa_o(fa), .fd_o(fdo), .fd_oe_o(fd_oe), .fd_i(fdi)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  // flash model: DQ6 flips after each read while busy, DQ5 set once remaining <= d5at
  int m_busy = 0, m_d5at = -1;
  logic m_tog = 1'b0, m_d5;
  assign m_d5 = (m_d5at >= 0) && (m_busy <= m_d5at);
  assign fdi = {1'b0, m_tog, m_d5, 5'b0};

  logic [AW+7:0] exp_q[$];
  logic [AW-1:0] exp_poll = '0;
  int n_reads = 0, we_len = 0, oe_len = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] wa, ra;
  logic [7:0] wd;

  task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", t, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sec_addr(input int i);
    return {i[2:0], 16'h0};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) chk(oe_n && !ce_n && fd_oe, "R3 strobes in write", {oe_n, ce_n, fd_oe}, 3'b101);
      if (we_n && fd_oe) chk(0, "R3 drive outside write", 1, 0);
      if (!oe_n) chk(we_n && !ce_n, "R6 strobes in read", {we_n, ce_n}, 2'b10);
      if (!busy) chk(ce_n && we_n && oe_n, "R13 idle strobes", {ce_n, we_n, oe_n}, 3'b111);
      if (!we_n) begin we_len++; wa = fa; wd = fdo; end
      if (we_n && !prev_we) begin
        chk(we_len == WE_LO, "R3 we low width", we_len, WE_LO);
        if (exp_q.size() == 0) chk(0, {tag, " unexpected write"}, {wa, wd}, 0);
        else begin
          logic [AW+7:0] e;
          e = exp_q.pop_front();
          chk({wa, wd} == e, {tag, " write addr/data"}, {wa, wd}, e);
        end
        we_len = 0;
      end
      if (!oe_n) begin oe_len++; ra = fa; end
      if (oe_n && !prev_oe) begin
        chk(oe_len == RD_DLY, "R6 read width", oe_len, RD_DLY);
        chk(ra == exp_poll, {tag, " R6 poll address"}, ra, exp_poll);
        n_reads++;
        if (m_busy > 0) begin m_tog = ~m_tog; m_busy--; end
        oe_len = 0;
      end
      prev_we = we_n;
      prev_oe = oe_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  // reference of the poll algorithm on the abstract flash model
  function automatic void ref_poll(input int busy0, input int d5at, output int reads, output bit e);
    int b = busy0, pairs = 0;
    bit t = 0, rech = 0;
    bit t1, t2, d2;
    reads = 0;
    forever begin
      t1 = t; if (b > 0) begin t = ~t; b--; end
      d2 = (d5at >= 0) && (b <= d5at);
      t2 = t; if (b > 0) begin t = ~t; b--; end
      reads += 2;
      if (t1 == t2) begin e = 0; return; end
      if (rech) begin e = 1; return; end
      if (d2) rech = 1;
      else if (pairs == PMAX - 1) begin e = 1; return; end
      else pairs++;
    end
  endfunction

  task automatic push_w(input logic [AW-1:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic push_prefix(input logic [7:0] third);
    push_w(19'h05555, 8'hAA); push_w(19'h02AAA, 8'h55); push_w(19'h05555, third);
  endtask

  task automatic run_op(input string t, input logic [1:0] o, input logic [AW-1:0] a,
                        input logic [7:0] d, input logic [NSEC-1:0] m, input int bsy,
                        input int d5at, input bit bad, input bit poke);
    int exp_reads, lat;
    bit exp_err;
    tag = t;
    m_busy = bsy; m_d5at = d5at; m_tog = 1'b0; n_reads = 0;
    if (bad) begin exp_reads = 0; exp_err = 1; end
    else ref_poll(bsy, d5at, exp_reads, exp_err);
    if (!bad) begin
      if (o == 2'd0) begin push_prefix(8'hA0); push_w(a, d); exp_poll = a; end
      else if (o == 2'd1) begin
        push_prefix(8'h80); push_w(19'h05555, 8'hAA); push_w(19'h02AAA, 8'h55);
        push_w(19'h05555, 8'h10); exp_poll = a;
      end else begin
        bit first = 1;
        push_prefix(8'h80); push_w(19'h05555, 8'hAA); push_w(19'h02AAA, 8'h55);
        for (int i = 0; i < NSEC; i++) if (m[i]) begin
          push_w(sec_addr(i), 8'h30);
          if (first) exp_poll = sec_addr(i);
          first = 0;
        end
      end
      if (exp_err) push_w(exp_poll, 8'hF0);
    end
    @(negedge clk);
    req = 1; op = o; addr = a; data = d; mask = m;
    @(negedge clk);
    req = 0; op = 2'd3; mask = '0;
    lat = 1;
    while (!done && lat < 5000) begin
      if (poke && lat == 10) begin req = 1; op = 2'd1; end
      else req = 0;
      @(negedge clk);
      lat++;
    end
    req = 0;
    chk(done, {t, " R13 done seen"}, done, 1);
    chk(err == exp_err, {t, " err_o (R7/R8/R9/R10/R11)"}, err, exp_err);
    chk(n_reads == exp_reads, {t, " poll read count"}, n_reads, exp_reads);
    chk(exp_q.size() == 0, {t, " missing writes"}, exp_q.size(), 0);
    if (bad) chk(lat == 1, {t, " R11 latency"}, lat, 1);
    @(negedge clk);
    chk(!done && !busy, {t, " R13 single pulse"}, {done, busy}, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && !fd_oe && !busy && !done && !err, "R1 in reset",
        {ce_n, we_n, oe_n, fd_oe, busy, done, err}, 7'b1110000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && we_n && oe_n && !fd_oe && !busy, "R1 after reset",
        {ce_n, we_n, oe_n, fd_oe, busy}, 5'b11100);
    run_op("R2 R7 R12 program", 2'd0, 19'h41234, 8'h5A, '0, 3, -1, 0, 1);
    run_op("R4 R7 chip erase", 2'd1, 19'h7FFFF, 8'h00, 8'hFF, 0, -1, 0, 0);
    run_op("R5 sector multi", 2'd2, 19'h00000, 8'h00, 8'b1010_0100, 5, -1, 0, 0);
    run_op("R5 sector top", 2'd2, 19'h00000, 8'h00, 8'h80, 1, -1, 0, 0);
    run_op("R8 late stop", 2'd0, 19'h00010, 8'h01, '0, 3, 1, 0, 0);
    run_op("R8 R9 dq5 fail", 2'd0, 19'h3ABCD, 8'h77, '0, INF, INF, 0, 0);
    run_op("R10 watchdog", 2'd2, 19'h00000, 8'h00, 8'b0100_0000, INF, -1, 0, 0);
    run_op("R11 empty mask", 2'd2, 19'h00000, 8'h00, 8'h00, 0, -1, 1, 0);
    run_op("R11 reserved op", 2'd3, 19'h00000, 8'h00, 8'hFF, 0, -1, 1, 0);
    run_op("R2 R7 program 0", 2'd0, 19'h00000, 8'h00, '0, 0, -1, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule